// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Bank

This block produces ten clock-enable streams from one fast source clock. Each stream pulses once every N+1 source cycles, where N is a 3-bit ratio held in one of two control words. The first word carries eight ratios and the second carries two. A downstream gated clock cell, or a register that counts enables, turns each stream into a slower clock for the processor domain.

A new ratio never cuts a period short. A write only stages the value, and each channel adopts it at the moment its own counter wraps. Until then, the channel's busy flag stays set in a status word. Busy flags are the only status the bank reports.

The controller that drives the bank works in two steps. It writes the first word and polls the first status word until it reads zero. Only then does it write the second word, and it polls the second status word until that also clears. The bank enforces this order: it ignores a write to the second word while any first-word channel is still busy.

Top module: `clkdiv_bank`

## Requirements
- R1: After reset, every ratio is 0, every busy flag is 0, all four read addresses return zero, and every enable output is high on every cycle.
- R2: Read address 0 returns the first control word. Its eight ratios sit at bits [4i+2:4i], for i = 0 to 7, and ratio i drives enable output i. A write with wrSel = 0 loads all eight ratios.
- R3: Read address 1 returns the second control word. Its two ratios sit at bits [2:0] and [6:4] and drive enable outputs 8 and 9. A write with wrSel = 1 loads both ratios.
- R4: Bits outside the ratio fields are not stored. They always read as 0, whatever value was written to them.
- R5: Read address 2 returns the busy flags of the first word, with the flag for channel i at bit 4i (mask 0x11111111). Read address 3 returns the busy flags of the second word at bits 0 and 4 (mask 0x11). A channel's flag is set in the cycle after a write that loads it.
- R6: A channel with ratio N raises its enable for one cycle in every N+1 source cycles, so it divides by 1 to 8.
- R7: A channel adopts a staged ratio only in the cycle its enable is high, which is its counter wrap. Its busy flag clears in that same cycle, so the cycle before the flag reads 0 shows the enable high.
- R8: Rewriting a ratio with its current value still sets the busy flag. The flag clears within 8 cycles, and the enable period stays the same.
- R9: While any first-word busy flag is set, a write to the second word is ignored. The second word and its busy flags stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast source clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrSel | input | 1 | Selects the word: 0 is the first control word, 1 is the second |
| wrData | input | 32 | Write data; only the ratio fields are used |
| rdAddr | input | 2 | Read select: 0 first word, 1 second word, 2 first status, 3 second status |
| rdData | output | 32 | Combinational read data |
| clkEn | output | 10 | One enable output per channel; bit i belongs to channel i |

## Verification
The assertions check four things on every cycle:
- a busy flag rises after each load;
- a flag falls only on a wrap cycle;
- a channel's active ratio holds steady while no change is pending;
- the pending time stays within eight cycles, and a second-word write made while the first word is busy leaves the second word unchanged.

Only the bench scenarios can show the rest:
- each channel's actual enable period for a range of ratios, including divide-by-1 and divide-by-8;
- the field placement and masking of non-field bits as seen through the read port;
- the full two-step update order driven the way a controller would drive it.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int FIELD_W = 3;
  localparam int NIB_W   = FIELD_W + 1;
  localparam int NUM_A   = 8;
  localparam int NUM_B   = 2;
  localparam int NUM_F   = NUM_A + NUM_B;

  typedef struct packed {
    logic [NUM_F-1:0]              load;
    logic [NUM_F-1:0][FIELD_W-1:0] ratio;
  } divCmd_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wrSel,
  input  logic [DW-1:0] wrData,
  input  logic [1:0]    rdAddr,
  output logic [DW-1:0] rdData,
  input  logic [NUM_F-1:0] busy,
  output divCmd_t       cmd
);
  logic [NUM_F-1:0][FIELD_W-1:0] fieldQ;
  logic [NUM_F-1:0]              loadVec;
  logic anyBusyA;
  logic wrA;
  logic wrB;

  assign anyBusyA = |busy[NUM_A-1:0];
  assign wrA = wrEn && !wrSel;
  // second word is held off until the first word has settled
  assign wrB = wrEn && wrSel && !anyBusyA;

  for (genvar i = 0; i < NUM_F; i++) begin : g_field
    localparam bit IS_A = (i < NUM_A);
    localparam int SLOT = IS_A ? i : i - NUM_A;
    assign loadVec[i] = IS_A ? wrA : wrB;
    always_ff @(posedge clk) begin
      if (!rstN)           fieldQ[i] <= '0;
      else if (loadVec[i]) fieldQ[i] <= wrData[SLOT*NIB_W +: FIELD_W];
    end
  end

  assign cmd.load  = loadVec;
  assign cmd.ratio = fieldQ;

  always_comb begin
    rdData = '0;
    case (rdAddr)
      2'd0: for (int i = 0; i < NUM_A; i++) rdData[i*NIB_W +: FIELD_W] = fieldQ[i];
      2'd1: for (int j = 0; j < NUM_B; j++) rdData[j*NIB_W +: FIELD_W] = fieldQ[NUM_A+j];
      2'd2: for (int i = 0; i < NUM_A; i++) rdData[i*NIB_W] = busy[i];
      default: for (int j = 0; j < NUM_B; j++) rdData[j*NIB_W] = busy[NUM_A+j];
    endcase
  end

  // R9
  wordb_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && anyBusyA) |=> $stable(fieldQ[NUM_F-1:NUM_A]));
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          load,
  input  logic [FW-1:0] ratio,
  output logic          en,
  output logic          busy
);
  localparam logic [FW:0] MAX_WAIT = (FW+1)'(2**FW);

  logic [FW-1:0] cnt;
  logic [FW-1:0] cur;
  logic [FW:0]   busyCnt;

  assign en = (cnt == cur);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      cur  <= '0;
      busy <= 1'b0;
    end else begin
      cnt <= en ? '0 : cnt + 1'b1;
      if (load) begin
        busy <= 1'b1;
      end else if (en && busy) begin
        cur  <= ratio;
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || load || !busy) busyCnt <= '0;
    else if (busyCnt != '1)     busyCnt <= busyCnt + 1'b1;
  end

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> busy);
  // R7
  busy_fall_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(en));
  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(cur));
  // R8
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= MAX_WAIT);
endmodule

// File: rtl/clkdiv_dpath.sv
module clkdiv_dpath
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divCmd_t          cmd,
  output logic [NUM_F-1:0] clkEn,
  output logic [NUM_F-1:0] busy
);
  for (genvar i = 0; i < NUM_F; i++) begin : g_chan
    clkdiv_chan #(.FW(FIELD_W)) chan_i (
      .clk  (clk),
      .rstN (rstN),
      .load (cmd.load[i]),
      .ratio(cmd.ratio[i]),
      .en   (clkEn[i]),
      .busy (busy[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [DW-1:0]    wrData,
  input  logic [1:0]       rdAddr,
  output logic [DW-1:0]    rdData,
  output logic [NUM_F-1:0] clkEn
);
  divCmd_t          cmd;
  logic [NUM_F-1:0] busy;

  clkdiv_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .cmd(cmd)
  );

  clkdiv_dpath dpath_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .clkEn(clkEn), .busy(busy)
  );
endmodule

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        wrSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [9:0]  clkEn;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 0;

  typedef struct {
    int    ch;
    int    per;
    string tag;
  } periodItem_t;
  periodItem_t sbQ[$];

  clkdiv_bank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .clkEn(clkEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // caller sits at a negedge; returns at the negedge after the write edge
  task automatic writeWord(input logic sel, input logic [31:0] d);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic waitIdle();
    logic [31:0] s2, s3;
    for (int k = 0; k < 40; k++) begin
      readReg(2'd2, s2);
      readReg(2'd3, s3);
      if ((s2 | s3) == 0) return;
      @(negedge clk);
    end
  endtask

  // counts cycles the channel's flag stays set; reports enable of the cycle before it cleared
  task automatic watchBusy(input int ch, output int cyc, output logic prevEn);
    logic [31:0] s;
    cyc = 0; prevEn = 1'b0;
    for (int k = 0; k < 20; k++) begin
      readReg(ch < 8 ? 2'd2 : 2'd3, s);
      if (s[(ch < 8 ? ch : ch - 8) * 4] == 1'b0) return;
      prevEn = clkEn[ch];
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic expectPeriod(input int ch, input int per, input string tag);
    periodItem_t it;
    it.ch = ch; it.per = per; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    while (sbQ.size() != 0) @(negedge clk);
  endtask

  // monitor: measures the enable spacing of the channel named by the head item
  initial begin
    forever begin
      periodItem_t it;
      int n;
      wait (sbQ.size() != 0);
      it = sbQ[0];
      @(negedge clk);
      while (!clkEn[it.ch]) @(negedge clk);
      n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!clkEn[it.ch]);
      check(it.tag, n, it.per);
      void'(sbQ.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [31:0] v, expA;
    int f[8];
    int cyc;
    logic pe;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      readReg(a[1:0], v);
      check($sformatf("R1 read addr %0d", a), v, 32'h0);
    end
    for (int k = 0; k < 3; k++) begin
      check("R1 enables high", {22'h0, clkEn}, 32'h3FF);
      @(negedge clk);
    end

    // R2 / R4 / R5: first word with spare bits set
    expA = '0;
    for (int i = 0; i < 8; i++) begin
      f[i] = (3 * i + 1) % 8;
      expA[4*i +: 3] = f[i][2:0];
    end
    writeWord(1'b0, expA | 32'h8888_8888);
    readReg(2'd0, v); check("R2 R4 first word readback", v, expA);
    readReg(2'd2, v); check("R5 first status set", v, 32'h1111_1111);
    readReg(2'd3, v); check("R5 second status clear", v, 32'h0);
    waitIdle();
    readReg(2'd2, v); check("R5 first status cleared", v, 32'h0);
    for (int i = 0; i < 8; i++) expectPeriod(i, f[i] + 1, $sformatf("R6 ch%0d period", i));
    drain();

    // R9: second word write while first word busy is ignored
    writeWord(1'b0, 32'h0);
    writeWord(1'b1, 32'hFFFF_FF35);
    readReg(2'd1, v); check("R9 second word unchanged", v, 32'h0);
    readReg(2'd3, v); check("R9 second status unchanged", v, 32'h0);
    waitIdle();

    // R3 / R4 / R5: second word
    writeWord(1'b1, 32'hFFFF_FF35);
    readReg(2'd1, v); check("R3 R4 second word readback", v, 32'h35);
    readReg(2'd3, v); check("R5 second status set", v, 32'h11);
    waitIdle();
    expectPeriod(8, 6, "R3 R6 ch8 period");
    expectPeriod(9, 4, "R3 R6 ch9 period");
    expectPeriod(0, 1, "R6 ch0 divide by 1");
    drain();

    // R7: change from divide-by-1 adopts at the very next cycle
    writeWord(1'b0, 32'h7777_7777);
    watchBusy(0, cyc, pe);
    check("R7 busy length from ratio 0", cyc, 1);
    check("R7 wrap before clear (ratio 0)", {31'h0, pe}, 32'h1);
    waitIdle();
    expectPeriod(0, 8, "R6 ch0 divide by 8");
    drain();

    // R7: change from divide-by-8 waits for the wrap
    writeWord(1'b0, 32'h7777_7772);
    watchBusy(0, cyc, pe);
    check("R7 wrap before clear (ratio 7)", {31'h0, pe}, 32'h1);
    check("R7 busy within one old period", (cyc >= 1 && cyc <= 8) ? 32'h1 : 32'h0, 32'h1);
    waitIdle();
    expectPeriod(0, 3, "R7 ch0 new period");
    drain();

    // R8: same-value write
    writeWord(1'b0, 32'h7777_7772);
    watchBusy(1, cyc, pe);
    check("R8 same-value busy bounded", (cyc >= 1 && cyc <= 8) ? 32'h1 : 32'h0, 32'h1);
    waitIdle();
    readReg(2'd0, v); check("R8 word kept", v, 32'h7777_7772);
    expectPeriod(1, 8, "R8 ch1 period unchanged");
    drain();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule